// File: doc/BRIEF.md
# Pulse-Width Capture Channel

This block is one capture channel wrapped around a free-running down-counter. The counter steps down by one each clock and restarts from a programmed period after it reaches zero. A level signal enters through a synchronizer. When the channel is armed, each rising or falling transition on that signal stores the counter's present value in a register kept for that edge kind. The edge also raises a sticky flag, which software clears.

Each edge kind can be told to restart the counter from the period. With both restarts on, each stored value measures the phase that has just ended. A stored rising value of `c` means the input was low for `PERIOD + 1 - c` clocks. A stored falling value means the same for the high phase. Software programs the channel through a small register bus with separate write and read addresses. An interrupt line is high while an enabled flag is set.

Top module: `pulse_capture_unit`

## Requirements
- R1: The counter register (address 5) decreases by one on each clock. On the clock after it holds 0 it loads the period register (address 0).
- R2: A detected rising edge stores the counter value in the rising-capture register (address 3). The value stored is the one the counter held before any restart caused by that edge.
- R3: A detected falling edge stores the counter value in the falling-capture register (address 4). The value stored is the one the counter held before any restart caused by that edge.
- R4: When control bit 1 is set, the counter holds the period on the clock after a detected rising edge. With both restarts on, a low phase of L clocks stores PERIOD + 1 - L in the rising-capture register.
- R5: When control bit 2 is set, the counter holds the period on the clock after a detected falling edge. With both restarts on, a high phase of H clocks stores PERIOD + 1 - H in the falling-capture register.
- R6: Flags register (address 2): bit 0 is set by rising events and bit 1 by falling events. Each bit stays set until a write of 1 to that bit. If a clear and a new event of the same kind arrive in the same cycle, the bit stays set.
- R7: `irq` is high exactly while (flag bit 0 AND control bit 3) OR (flag bit 1 AND control bit 4) is true.
- R8: While control bit 0 (capture arm) is 0, input transitions have no effect: no capture, no flag and no counter restart.
- R9: A level change on `cap_in` that is set up before a clock edge becomes a capture event on the third clock edge after the change.
- R10: After reset every readable register and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register bus |
| wr_addr | input | 3 | Write address (0 period, 1 control, 2 flags clear) |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read address (0 to 5) |
| rd_data | output | CNT_W | Read data for `rd_addr`, combinational |
| cap_in | input | 1 | Asynchronous signal to measure |
| irq | output | 1 | Level interrupt from enabled flags |

## Verification
The bench uses the default parameters: a 16-bit counter and a two-stage synchronizer. At run time it writes small periods (3, 8 and 20), so counter wraps occur within a few dozen cycles. With those periods, the worked pulse case of period 8, a 4-clock low phase and a 2-clock high phase can be reached directly. Because the synchronizer depth is the default of 2, the exact third-edge detection latency can be observed cycle by cycle. It also makes it possible to time a flag-clear write into the very cycle of a new event.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RCAP   = 3'd3;
  localparam logic [ADDR_W-1:0] A_FCAP   = 3'd4;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd5;

  localparam int N_EDGE_KINDS = 2;
  localparam int CTRL_W       = 5;

  // control word, bit 0 is the LSB
  typedef struct packed {
    logic ie_fall;   // bit 4
    logic ie_rise;   // bit 3
    logic rld_fall;  // bit 2
    logic rld_rise;  // bit 1
    logic arm;       // bit 0
  } ctrl_t;

  // phase length in counter clocks from a stored down-count
  function automatic int unsigned phase_len(input int unsigned period,
                                            input int unsigned stored);
    return period + 1 - stored;
  endfunction
endpackage

// File: rtl/pcu_sync_edge.sv
module pcu_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level  = sync_q[SYNC_STAGES-1];
  assign rise_o = arm_i &  level & ~prev_q;
  assign fall_o = arm_i & ~level &  prev_q;

  // R9
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  // R9
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
  // R8
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |-> (!rise_o && !fall_o));
endmodule

// File: rtl/pcu_downcounter.sv
module pcu_downcounter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_i,
  input  logic         reload_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  function automatic logic [W-1:0] next_count(input logic [W-1:0] cur,
                                              input logic [W-1:0] per,
                                              input logic         rl);
    if (rl || cur == '0) return per;
    return cur - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_count(cnt_q, period_i, reload_i);
  end

  assign cnt_o = cnt_q;

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_i && cnt_q == '0) |=> cnt_q == $past(period_i));
  // R4 R5
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> cnt_q == $past(period_i));
endmodule

// File: rtl/pcu_flag.sv
module pcu_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/pulse_capture_unit.sv
module pulse_capture_unit
  import pcu_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [2:0]        rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              cap_in,
  output logic              irq
);
  logic [CNT_W-1:0]        period_q;
  ctrl_t                   ctrl_q;
  logic [CNT_W-1:0]        rcap_q, fcap_q, cnt;
  logic                    rise_evt, fall_evt, restart;
  logic                    wr_flags;
  logic [N_EDGE_KINDS-1:0] evt, flag_clr, flags, irq_en;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      ctrl_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_PERIOD) period_q <= wr_data;
      if (wr_addr == A_CTRL)   ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  pcu_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (ctrl_q.arm),
    .async_i (cap_in),
    .rise_o  (rise_evt),
    .fall_o  (fall_evt)
  );

  assign restart = (rise_evt & ctrl_q.rld_rise) | (fall_evt & ctrl_q.rld_fall);

  pcu_downcounter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_q),
    .reload_i (restart),
    .cnt_o    (cnt)
  );

  // capture registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcap_q <= '0;
      fcap_q <= '0;
    end else begin
      if (rise_evt) rcap_q <= cnt;
      if (fall_evt) fcap_q <= cnt;
    end
  end

  // sticky flags, index 0 rising, index 1 falling
  assign wr_flags = wr_en && (wr_addr == A_FLAGS);
  assign evt      = {fall_evt, rise_evt};
  assign flag_clr = {N_EDGE_KINDS{wr_flags}} & wr_data[N_EDGE_KINDS-1:0];

  for (genvar g = 0; g < N_EDGE_KINDS; g++) begin : g_flag
    pcu_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt[g]),
      .clr_i  (flag_clr[g]),
      .flag_o (flags[g])
    );
  end

  assign irq_en = {ctrl_q.ie_fall, ctrl_q.ie_rise};
  assign irq    = |(flags & irq_en);

  always_comb begin
    case (rd_addr)
      A_PERIOD: rd_data = period_q;
      A_CTRL:   rd_data = CNT_W'(ctrl_q);
      A_FLAGS:  rd_data = CNT_W'(flags);
      A_RCAP:   rd_data = rcap_q;
      A_FCAP:   rd_data = fcap_q;
      A_COUNT:  rd_data = cnt;
      default:  rd_data = '0;
    endcase
  end

  // R2
  rcap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> rcap_q == $past(cnt));
  // R2
  rcap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(rcap_q));
  // R3
  fcap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> fcap_q == $past(cnt));
  // R4
  rise_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && ctrl_q.rld_rise) |=> cnt == $past(period_q));
  // R5
  fall_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && ctrl_q.rld_fall) |=> cnt == $past(period_q));
  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);
  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && ctrl_q.ie_rise) |-> irq);
endmodule

// File: tb/sim_pulse_capture_unit.sv
`timescale 1ns/1ps
module sim_pulse_capture_unit;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         cap_in = 1'b0;
  logic         irq;

  always #4 clk = ~clk;  // 125 MHz

  pulse_capture_unit #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cap_in(cap_in), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model, written from the requirements
  logic [W-1:0] m_per, m_cnt, m_rcap, m_fcap;
  logic [4:0]   m_ctrl;
  logic         m_fr, m_ff, m_s1, m_s2, m_pv;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_per = 0; m_cnt = 0; m_rcap = 0; m_fcap = 0; m_ctrl = 0;
      m_fr = 0; m_ff = 0; m_s1 = 0; m_s2 = 0; m_pv = 0;
    end else begin
      logic r, f;
      r = m_ctrl[0] && m_s2 && !m_pv;
      f = m_ctrl[0] && !m_s2 && m_pv;
      if (r) m_rcap = m_cnt;
      if (f) m_fcap = m_cnt;
      if ((r && m_ctrl[1]) || (f && m_ctrl[2])) m_cnt = m_per;
      else if (m_cnt == 0) m_cnt = m_per;
      else m_cnt = m_cnt - 1;
      if (wr_en && wr_addr == 3'd2) begin
        if (wr_data[0]) m_fr = 0;
        if (wr_data[1]) m_ff = 0;
      end
      if (r) m_fr = 1;
      if (f) m_ff = 1;
      m_pv = m_s2; m_s2 = m_s1; m_s1 = cap_in;
      if (wr_en && wr_addr == 3'd0) m_per = wr_data;
      if (wr_en && wr_addr == 3'd1) m_ctrl = wr_data[4:0];
    end
  end

  // scoreboard: kind 0 register, 1 live counter, 2 irq
  typedef struct {
    string        tag;
    int           kind;
    logic [2:0]   addr;
    logic [W-1:0] exp;
  } item_t;
  item_t sb[$];

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [W-1:0] got, exp;
      it = sb.pop_front();
      rd_addr = (it.kind == 1) ? 3'd5 : it.addr;
      #1;
      exp = (it.kind == 1) ? m_cnt : it.exp;
      got = (it.kind == 2) ? W'(irq) : rd_data;
      n_cmp++;
      if (got !== exp) begin
        n_bad++;
        $display("FAIL %s: got %0d expected %0d", it.tag, got, exp);
      end
    end
  end

  task automatic push(input string tag, input int kind, input logic [2:0] a,
                      input logic [W-1:0] e);
    item_t it;
    it.tag = tag; it.kind = kind; it.addr = a; it.exp = e;
    sb.push_back(it);
  endtask

  task automatic drain();
    wait (sb.size() == 0);
    #3;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    step(1);
    wr_en = 1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 0;
  endtask

  task automatic irq_expect(input string tag);
    push(tag, 2, 3'd0, W'((m_fr & m_ctrl[3]) | (m_ff & m_ctrl[4])));
  endtask

  initial begin
    logic [W-1:0] keep;
    // R10 reset state
    step(2);
    for (int a = 0; a < 6; a++) push("R10 reset reg", 0, 3'(a), '0);
    push("R10 reset irq", 2, 3'd0, '0);
    drain();
    rst_n = 1;
    step(2);

    // R1 free counting and wrap with period 3
    wr(3'd0, 16'd3);
    for (int i = 0; i < 10; i++) begin push("R1 count", 1, 3'd5, '0); drain(); end

    // R1 with period 20, arm capture only
    wr(3'd0, 16'd20);
    wr(3'd1, 16'h01);
    step(7);
    // R9 detection latency: flag 0 after edges 1 and 2, set after edge 3
    cap_in = 1;
    push("R9 edge1", 0, 3'd2, 16'd0); step(1);
    push("R9 edge2", 0, 3'd2, 16'd0); step(1);
    push("R9 edge3", 0, 3'd2, 16'd1); step(1);
    drain();
    push("R2 rise capture", 0, 3'd3, m_rcap);
    irq_expect("R7 irq off");
    drain();

    // R3 falling capture
    step(5); cap_in = 0; step(6);
    push("R3 fall capture", 0, 3'd4, m_fcap);
    push("R6 both flags", 0, 3'd2, 16'd3);
    drain();

    // R6 write-1-to-clear of bit 0 only
    wr(3'd2, 16'd1); step(1);
    push("R6 clear rise", 0, 3'd2, 16'd2); drain();

    // R7 enables
    wr(3'd1, 16'h09); step(1);       // arm + ie_rise
    irq_expect("R7 rise enable only"); drain();
    push("R7 irq low", 2, 3'd0, 16'd0); drain();
    wr(3'd1, 16'h11); step(1);       // arm + ie_fall
    push("R7 irq high", 2, 3'd0, 16'd1); drain();
    wr(3'd2, 16'd3); step(1);
    push("R7 irq after clear", 2, 3'd0, 16'd0);
    push("R6 all cleared", 0, 3'd2, 16'd0); drain();

    // R6 set wins over same-cycle clear
    cap_in = 1; step(2);
    wr_en = 1; wr_addr = 3'd2; wr_data = 16'd1;
    step(1);
    wr_en = 0;
    step(1);
    push("R6 set wins", 0, 3'd2, 16'd1); drain();
    wr(3'd2, 16'd3); step(1);

    // R8 disarmed: reloads requested but capture off
    wr(3'd1, 16'h06);
    keep = m_rcap;
    step(3); cap_in = 0; step(6); cap_in = 1; step(6);
    push("R8 no flag", 0, 3'd2, 16'd0);
    push("R8 rcap kept", 0, 3'd3, keep);
    push("R8 no restart", 1, 3'd5, '0);
    drain();

    // R4 R5 pulse width with period 8 and both restarts
    wr(3'd0, 16'd8);
    wr(3'd1, 16'h07);
    step(20);
    cap_in = 0; step(4);   // low for 4 clocks
    cap_in = 1; step(2);   // high for 2 clocks
    cap_in = 0; step(6);
    push("R4 low width", 0, 3'd3, W'(8 + 1 - 4));
    push("R5 high width", 0, 3'd4, W'(8 + 1 - 2));
    push("R4 model", 0, 3'd3, m_rcap);
    drain();
    for (int i = 0; i < 4; i++) begin push("R1 count p8", 1, 3'd5, '0); drain(); end

    // R4 rising restart only, check counter lands on period
    wr(3'd1, 16'h03);
    step(2); cap_in = 1; step(3);
    push("R4 restart value", 1, 3'd5, '0); drain();
    push("R4 counter", 1, 3'd5, '0); drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule